// File: doc/BRIEF.md
# Configurable Registered Buffer with Parity

This block is the clocked address and command register that sits on a registered memory module between the controller and the memory devices. On every rising clock edge it captures a bank of data inputs and a pair of control inputs (clock enable and termination enable), and drives them out as registered signals. A two-bit configuration input selects the topology. In the wide one-to-one layout, 25 inputs each drive one output. In the narrow one-to-two layout, 14 inputs each drive an A copy and a B copy. The same two configuration bits also mark the narrow device as the first or the second register of a cascaded pair.

The block checks an even-parity code carried on a separate parity input against the data it covers. Each device produces a registered partial parity result. When two narrow devices share a module, the first device's partial result feeds the parity input of the second, and only the second raises the active-low error flag. A detected error is held low for two cycles by a small counter. When both chip-select inputs are high, the data outputs are frozen to save switching power and parity is not checked. An asynchronous active-low reset clears every registered output.

Top module: `cfg_regbuf`

## Requirements
- R1: Configuration bit 0 low selects the one-to-one layout, and configuration bit 1 is then ignored. Captured `d_in[24:0]` appears on `q_a`, and `q_b` stays low.
- R2: With configuration bit 0 high (one-to-two), `q_a[13:0]` and `q_b[13:0]` both carry the captured `d_in[13:0]`, and `q_a[24:14]` reads low.
- R3: Inputs are sampled on the rising clock edge. A registered output changes only after the edge that captured its new value.
- R4: The device is deselected only when both bits of `cs_n` are high. While it is deselected, `q_a`, `q_b` and `pp_out` hold their values, and `cke_q` and `odt_q` still follow `cke_in` and `odt_in` one clock later.
- R5: A low `rst_n` at once drives `q_a`, `q_b`, `cke_q`, `odt_q` and `pp_out` low and `err_n` high. After release with inputs low and the device deselected, the outputs stay at those values.
- R6: In the one-to-one layout, a selected cycle is an error when the count of ones over `d_in[24:0]` plus `par_in` is odd. `err_n` goes low after the edge that follows the capturing edge.
- R7: Cycles in which the device is deselected never cause an error, whatever `par_in` is.
- R8: After the last error, `err_n` stays low for exactly two cycles and then returns high.
- R9: Outside the second-device configuration, `pp_out` is the registered XOR of `par_in` and the covered data bits (all 25 in one-to-one, `d_in[13:0]` in one-to-two). It updates only on selected cycles.
- R10: In the first-device configuration (`cfg` = 01), `err_n` is held high.
- R11: In the second-device configuration (`cfg` = 11), `pp_out` is low. For data captured at edge k, the partial parity from the first device is taken on `par_in` at edge k+1, and a mismatch drives `err_n` low after edge k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg | input | 2 | Bit 0: one-to-two layout; bit 1: second device of a pair |
| cs_n | input | 2 | Active-low chip selects; both high means deselected |
| d_in | input | 25 | Data inputs |
| cke_in | input | 1 | Clock-enable control input |
| odt_in | input | 1 | Termination-enable control input |
| par_in | input | 1 | Parity bit or the upstream partial parity |
| q_a | output | 25 | Registered data, A copy |
| q_b | output | 14 | Registered data, B copy (one-to-two only) |
| cke_q | output | 1 | Registered clock enable |
| odt_q | output | 1 | Registered termination enable |
| pp_out | output | 1 | Registered partial parity for cascading |
| err_n | output | 1 | Active-low parity error flag |

## Verification
If the pipeline bit that records a selected cycle goes wrong, an error appears one or two cycles later on a deselected cycle, or a real error is missed. If the stretch counter goes wrong, the flag stays low for the wrong number of cycles after the last error. In a second device, a data-parity stage that is misaligned by one cycle shows up as errors shifted onto the wrong data, within two edges of capture. A fault in the gating shows as `q_a` or `pp_out` moving on the very next edge while both chip selects are high.

// File: rtl/cfg_regbuf_pkg.sv
package cfg_regbuf_pkg;
  typedef enum logic [1:0] {
    TOPO_WIDE   = 2'd0,
    TOPO_FIRST  = 2'd1,
    TOPO_SECOND = 2'd2
  } topo_e;

  function automatic topo_e decode_topo(input logic [1:0] cfg_bits);
    if (!cfg_bits[0])     return TOPO_WIDE;
    else if (cfg_bits[1]) return TOPO_SECOND;
    else                  return TOPO_FIRST;
  endfunction
endpackage

// File: rtl/cfg_regbuf_dpath.sv
module cfg_regbuf_dpath
  import cfg_regbuf_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  topo_e               topo,
  input  logic                sel,
  input  logic [WIDE_W-1:0]   d,
  input  logic                cke_in,
  input  logic                odt_in,
  output logic [WIDE_W-1:0]   q_a,
  output logic [NARROW_W-1:0] q_b,
  output logic                cke_q,
  output logic                odt_q
);
  localparam logic [WIDE_W-1:0] NMASK = {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic                narrow;
  logic [WIDE_W-1:0]   qa_nxt;
  logic [NARROW_W-1:0] qb_nxt;

  always_comb begin
    narrow = (topo != TOPO_WIDE);
    qa_nxt = narrow ? (d & NMASK) : d;
    qb_nxt = narrow ? d[NARROW_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_a   <= '0;
      q_b   <= '0;
      cke_q <= 1'b0;
      odt_q <= 1'b0;
    end else begin
      cke_q <= cke_in;
      odt_q <= odt_in;
      if (sel) begin
        q_a <= qa_nxt;
        q_b <= qb_nxt;
      end
    end
  end

  AST_HOLD_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ($stable(q_a) && $stable(q_b))); // R4
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && narrow) |=> (q_a[WIDE_W-1:NARROW_W] == '0)); // R2
endmodule

// File: rtl/cfg_regbuf_parity.sv
module cfg_regbuf_parity
  import cfg_regbuf_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  topo_e             topo,
  input  logic              sel,
  input  logic [WIDE_W-1:0] d,
  input  logic              par_in,
  output logic              pp_out,
  output logic              mism
);
  localparam logic [WIDE_W-1:0] NMASK = {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic dpar;
  logic sel1_q, dp1_q, pin1_q;
  logic sel2_q, dp2_q;
  logic pp_q;

  always_comb begin
    dpar   = ^(d & ((topo == TOPO_WIDE) ? {WIDE_W{1'b1}} : NMASK));
    if (topo == TOPO_SECOND) mism = sel2_q & (dp2_q ^ pin1_q);
    else                     mism = sel1_q & (dp1_q ^ pin1_q);
    pp_out = (topo == TOPO_SECOND) ? 1'b0 : pp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel1_q <= 1'b0;
      dp1_q  <= 1'b0;
      pin1_q <= 1'b0;
      sel2_q <= 1'b0;
      dp2_q  <= 1'b0;
      pp_q   <= 1'b0;
    end else begin
      sel1_q <= sel;
      dp1_q  <= dpar;
      pin1_q <= par_in;
      sel2_q <= sel1_q;
      dp2_q  <= dp1_q;
      if (sel) pp_q <= dpar ^ par_in;
    end
  end

  AST_DESEL_NO_MISM: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && topo == TOPO_WIDE) |=> !mism); // R7
endmodule

// File: rtl/cfg_regbuf_errflag.sv
module cfg_regbuf_errflag
  import cfg_regbuf_pkg::*;
#(
  parameter int HOLD_CYC = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  topo_e topo,
  input  logic  mism,
  output logic  err_n
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             err_nxt;
  logic             is_first;

  always_comb begin
    is_first = (topo == TOPO_FIRST);
    cnt_nxt  = cnt_q;
    err_nxt  = 1'b1;
    if (is_first) begin
      cnt_nxt = '0;
    end else if (mism) begin
      cnt_nxt = RELOAD;
      err_nxt = 1'b0;
    end else if (cnt_q != '0) begin
      cnt_nxt = cnt_q - 1'b1;
      err_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_n <= 1'b1;
    end else begin
      cnt_q <= cnt_nxt;
      err_n <= err_nxt;
    end
  end

  AST_FIRST_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    is_first |=> err_n); // R10
  AST_ERR_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_n) |=> (!err_n || $past(is_first))); // R8
  AST_ERR_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_n) |-> (($past(err_n, 2) == 1'b0) || $past(is_first))); // R8
endmodule

// File: rtl/cfg_regbuf.sv
module cfg_regbuf
  import cfg_regbuf_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14,
  parameter int HOLD_CYC = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg,
  input  logic [1:0]          cs_n,
  input  logic [WIDE_W-1:0]   d_in,
  input  logic                cke_in,
  input  logic                odt_in,
  input  logic                par_in,
  output logic [WIDE_W-1:0]   q_a,
  output logic [NARROW_W-1:0] q_b,
  output logic                cke_q,
  output logic                odt_q,
  output logic                pp_out,
  output logic                err_n
);
  logic [1:0] rst_sync_q;
  logic       rst_i;
  topo_e      topo;
  logic       sel;
  logic       mism;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  always_comb begin
    rst_i = rst_sync_q[1];
    topo  = decode_topo(cfg);
    sel   = ~(cs_n[0] & cs_n[1]);
  end

  cfg_regbuf_dpath #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_dpath (
    .clk(clk), .rst_n(rst_i), .topo(topo), .sel(sel), .d(d_in),
    .cke_in(cke_in), .odt_in(odt_in),
    .q_a(q_a), .q_b(q_b), .cke_q(cke_q), .odt_q(odt_q)
  );

  cfg_regbuf_parity #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_parity (
    .clk(clk), .rst_n(rst_i), .topo(topo), .sel(sel), .d(d_in),
    .par_in(par_in), .pp_out(pp_out), .mism(mism)
  );

  cfg_regbuf_errflag #(.HOLD_CYC(HOLD_CYC)) u_err (
    .clk(clk), .rst_n(rst_i), .topo(topo), .mism(mism), .err_n(err_n)
  );

  AST_PP_SECOND_LOW: assert property (@(posedge clk) disable iff (!rst_i)
    (topo == TOPO_SECOND) |=> (pp_out == 1'b0 || topo != TOPO_SECOND)); // R11
endmodule

// File: tb/cfg_regbuf_test.sv
module cfg_regbuf_test;
  localparam logic [24:0] WMASK = 25'h1FF_FFFF;
  localparam logic [24:0] NMASK = 25'h000_3FFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg;
  logic [1:0]  cs_n;
  logic [24:0] d_in;
  logic        cke_in, odt_in, par_in;
  logic [24:0] q_a;
  logic [13:0] q_b;
  logic        cke_q, odt_q, pp_out, err_n;

  int checks = 0;
  int errors = 0;
  int cur_mode;

  logic [24:0] m_qa;
  logic [13:0] m_qb;
  logic m_cke, m_odt, m_pp, m_err;
  logic m_sel1, m_dp1, m_pin1, m_sel2, m_dp2;
  int   m_cnt;

  always #10 clk = ~clk;

  cfg_regbuf uut (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .cs_n(cs_n), .d_in(d_in),
    .cke_in(cke_in), .odt_in(odt_in), .par_in(par_in),
    .q_a(q_a), .q_b(q_b), .cke_q(cke_q), .odt_q(odt_q),
    .pp_out(pp_out), .err_n(err_n)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    m_qa = '0; m_qb = '0; m_cke = 0; m_odt = 0; m_pp = 0; m_err = 1;
    m_sel1 = 0; m_dp1 = 0; m_pin1 = 0; m_sel2 = 0; m_dp2 = 0; m_cnt = 0;
  endtask

  task automatic compare_all();
    check(cur_mode == 0 ? "R1" : "R2", "q_a", 64'(q_a), 64'(m_qa));
    check(cur_mode == 0 ? "R1" : "R2", "q_b", 64'(q_b), 64'(m_qb));
    check("R4", "cke_q", 64'(cke_q), 64'(m_cke));
    check("R4", "odt_q", 64'(odt_q), 64'(m_odt));
    check(cur_mode == 2 ? "R11" : "R9", "pp_out", 64'(pp_out),
          64'(cur_mode == 2 ? 1'b0 : m_pp));
    check(cur_mode == 1 ? "R10" : (cur_mode == 2 ? "R11" : "R6"), "err_n",
          64'(err_n), 64'(m_err));
  endtask

  task automatic step();
    logic sel, dp, mis;
    @(posedge clk);
    sel = (cs_n != 2'b11);
    dp  = ^(d_in & (cur_mode == 0 ? WMASK : NMASK));
    mis = (cur_mode == 2) ? (m_sel2 & (m_dp2 ^ m_pin1)) : (m_sel1 & (m_dp1 ^ m_pin1));
    if (cur_mode == 1) begin m_err = 1; m_cnt = 0; end
    else if (mis) begin m_err = 0; m_cnt = 1; end
    else if (m_cnt != 0) begin m_cnt--; m_err = 0; end
    else m_err = 1;
    m_sel2 = m_sel1; m_dp2 = m_dp1;
    m_sel1 = sel; m_dp1 = dp; m_pin1 = par_in;
    if (sel) begin
      m_pp = dp ^ par_in;
      m_qa = (cur_mode == 0) ? d_in : (d_in & NMASK);
      m_qb = (cur_mode == 0) ? 14'd0 : d_in[13:0];
    end
    m_cke = cke_in; m_odt = odt_in;
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_inputs();
    cs_n = 2'b11; d_in = '0; cke_in = 0; odt_in = 0; par_in = 0;
  endtask

  task automatic do_reset(input logic [1:0] c, input int mode);
    rst_n = 0; idle_inputs(); cfg = c; cur_mode = mode;
    model_clear();
    repeat (2) @(negedge clk);
    check("R5", "q_a in reset", 64'(q_a), 64'd0);
    check("R5", "err_n in reset", 64'(err_n), 64'd1);
    rst_n = 1;
    for (int i = 0; i < 4; i++) step();
  endtask

  task automatic rand_run(input int n);
    for (int i = 0; i < n; i++) begin
      d_in   = 25'($urandom);
      cs_n   = 2'($urandom);
      cke_in = 1'($urandom);
      odt_in = 1'($urandom);
      par_in = (^(d_in & (cur_mode == 0 ? WMASK : NMASK))) ^ ($urandom % 5 == 0);
      step();
    end
  endtask

  task automatic set_sel(input logic [24:0] d, input logic bad);
    cs_n = 2'b01; d_in = d;
    par_in = (^(d & (cur_mode == 0 ? WMASK : NMASK))) ^ bad;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 0; cfg = 0; idle_inputs();

    // One-to-one layout
    do_reset(2'b00, 0);
    set_sel(25'h155_AAAA, 0); cke_in = 1;
    check("R3", "q_a before edge", 64'(q_a), 64'd0);
    step();
    check("R3", "q_a after edge", 64'(q_a), 64'h155_AAAA);
    // deselected hold, control still follows
    cs_n = 2'b11; d_in = 25'h0F0_F0F0; cke_in = 0; odt_in = 1;
    step();
    check("R4", "q_a held", 64'(q_a), 64'h155_AAAA);
    check("R4", "odt_q follows", 64'(odt_q), 64'd1);
    // single chip select low still selects
    cs_n = 2'b10; step();
    check("R4", "cs_n=10 selects", 64'(q_a), 64'h0F0_F0F0);
    // error stretch
    set_sel(25'h000_0007, 1); step();
    set_sel(25'h000_0003, 0); step();
    check("R6", "err after bad", 64'(err_n), 64'd0);
    step(); check("R8", "err held 2nd", 64'(err_n), 64'd0);
    step(); check("R8", "err released", 64'(err_n), 64'd1);
    // deselected bad parity
    cs_n = 2'b11; par_in = ~par_in; step();
    step(); step();
    check("R7", "no err when deselected", 64'(err_n), 64'd1);
    // back-to-back errors
    set_sel(25'h1, 1); step(); step(); step();
    check("R8", "err re-armed", 64'(err_n), 64'd0);
    set_sel(25'h1, 0); step(); step(); step();
    check("R8", "err cleared", 64'(err_n), 64'd1);
    rand_run(400);

    // async reset mid-run
    @(negedge clk); set_sel(25'h1FF_FFFF, 0); step();
    #5 rst_n = 0; #1;
    check("R5", "async q_a", 64'(q_a), 64'd0);
    check("R5", "async pp_out", 64'(pp_out), 64'd0);
    check("R5", "async err_n", 64'(err_n), 64'd1);

    // cfg bit1 ignored in one-to-one
    @(negedge clk); do_reset(2'b10, 0);
    set_sel(25'h1AB_CDEF, 0); step();
    check("R1", "cfg 10 wide", 64'(q_a), 64'h1AB_CDEF);
    rand_run(200);

    // one-to-two, first device
    do_reset(2'b01, 1);
    set_sel(25'h1FF_C123, 0); step();
    check("R2", "upper low", 64'(q_a), 64'h000_0123);
    check("R2", "b copy", 64'(q_b), 64'h0123);
    set_sel(25'h2, 1); step(); step();
    check("R10", "first err high", 64'(err_n), 64'd1);
    rand_run(400);

    // one-to-two, second device
    do_reset(2'b11, 2);
    set_sel(25'h3, 0); par_in = 0; step();
    cs_n = 2'b01; d_in = 0; par_in = 1; step();
    step();
    check("R11", "second err after k+2", 64'(err_n), 64'd0);
    check("R11", "second pp low", 64'(pp_out), 64'd0);
    rand_run(400);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule